// File: doc/BRIEF.md
# Reset and Strap Configuration Controller

This block manages the way a multi-port switch leaves a fundamental reset. It runs the reset input through a two-flop synchronizer. It records the configuration straps on every clock while the synchronized reset is active, so the values it keeps are the ones present at the release edge. It then holds those values until the next reset. The straps cover the operating mode, the merge setting of each port pair, the two common-clock flags, the management-bus speed and the halt request.

The kept mode value is decoded into three outputs: a serial EEPROM load enable, an upstream failover enable and an upstream port number. A reserved code sets an error flag and falls back to plain operation. For each port pair the block drives a merge flag and a per-lane map. The map gives every physical lane an owning port and a logical lane number.

When the halt strap was high at release, the core stays in reset while the management side runs. It stays there until software writes a zero to the halt bit through a one-bit register write port. A one-cycle done pulse marks entry into normal operation on either path.

Top module: `rstcfg_ctrl`

## Requirements
- R1: While `rst_fund` is high, `core_rst` is 1 and `mgmt_active`, `halted` and `cfg_done` are 0. After `rst_fund` falls (sampled low at edge E0), `core_rst` stays 1 through edge E1 and can first go low after edge E2.
- R2: Straps are sampled on every edge while the synchronized reset is active and held afterwards. A strap pin that changes after release has no effect on any output until the next reset. `cclk_dn`, `cclk_up` and `smb_slow` present the held strap values.
- R3: Mode decode for codes that are not reserved. 0x0 gives no EEPROM and no failover. 0x1 gives EEPROM only. 0x8 gives failover with upstream port 0. 0x9 gives failover with upstream port 2. 0xA gives EEPROM and failover with port 0. 0xB gives EEPROM and failover with port 2. `upstream_port` is 0 whenever failover is off.
- R4: Mode codes 0x2 to 0x7 and 0xC to 0xF set `cfg_error`. For these codes `eeprom_init_en` and `failover_en` are 0 and `upstream_port` is 0.
- R5: Merge straps are active low, one per pair p. When a strap is 0, `pair_merged[p]` is 1 and all eight physical lanes k (0..7) of the pair belong to port 2p as logical lane k.
- R6: When the merge strap of pair p is 1, `pair_merged[p]` is 0. Lanes 0..3 belong to port 2p as logical lanes 0..3, and lanes 4..7 belong to port 2p+1 as logical lanes 0..3. Lane n of the chip is field n of `lane_port` (3 bits each) and of `lane_sub` (3 bits each), where n = 8p + k.
- R7: `smb_slow` (1 selects 100 kHz, 0 selects 400 kHz) follows only the held strap. No register write changes it.
- R8: If `strap_halt` was high at release, then after edge E2 the block is halted: `halted` is 1, `mgmt_active` is 1, `core_rst` is 1 and `cfg_done` is 0.
- R9: While halted, the only write that releases the block is `ctl_we`=1 with `ctl_addr`=`CTL_ADDR` (default 0) and `ctl_wdata`=0. Writes to other addresses, or with data 1, leave it halted.
- R10: `cfg_done` is high for exactly one cycle. It goes high in the cycle the block enters normal operation, either straight from reset or on release from halt.
- R11: Once running, register writes of any value at any address leave `core_rst` at 0 and `halted` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_fund | input | 1 | Fundamental reset, active high |
| strap_mode | input | 4 | Operating mode strap |
| strap_merge_n | input | NPAIR | Pair merge straps, active low |
| strap_smb_slow | input | 1 | Management bus slow-speed strap |
| strap_cclk_dn | input | 1 | Common clock toward downstream strap |
| strap_cclk_up | input | 1 | Common clock toward upstream strap |
| strap_halt | input | 1 | Halt-after-reset strap |
| ctl_we | input | 1 | Control register write strobe |
| ctl_addr | input | ADDR_W | Control register write address |
| ctl_wdata | input | 1 | Value written to the halt bit |
| core_rst | output | 1 | Core logic held in reset |
| halted | output | 1 | Halted waiting for software |
| mgmt_active | output | 1 | Management interfaces may run |
| cfg_done | output | 1 | One-cycle entry into normal operation |
| cfg_error | output | 1 | Reserved mode code was sampled |
| eeprom_init_en | output | 1 | Serial EEPROM load enabled |
| failover_en | output | 1 | Upstream failover enabled |
| upstream_port | output | PORT_W | Selected upstream port |
| smb_slow | output | 1 | Held management bus speed strap |
| cclk_dn | output | 1 | Held downstream common clock strap |
| cclk_up | output | 1 | Held upstream common clock strap |
| pair_merged | output | NPAIR | Pair is one x8 port |
| lane_port | output | NLANE*PORT_W | Owning port per physical lane |
| lane_sub | output | NLANE*3 | Logical lane number per physical lane |

## Verification
The bench counts edges after reset release. A synchronizer that is one stage short, or a sequencer that skips its reset state, would drop `core_rst` one cycle early and would be caught. Every mode code of interest is tried: each valid one, and reserved codes at both ends of both reserved ranges. A decoder that ignores a bit would mix up the port-0 and port-2 failover selection, and one that misses a reserved range would leave `cfg_error` low with live enables. Strap pins are changed after release to catch latching that stays transparent. In the halted state, writes with the wrong address and with the wrong data are applied to catch a release condition that is too loose. Writes while running are applied to catch a halt bit that can be set again, or a speed selection that software can change.

// File: rtl/rstcfg_pkg.sv
package rstcfg_pkg;

    localparam int MODE_W         = 4;
    localparam int LANES_PER_PAIR = 8;
    localparam int HALF_LANES     = LANES_PER_PAIR / 2;
    localparam int LANE_IDX_W     = $clog2(LANES_PER_PAIR);

    typedef enum logic [1:0] {
        SEQ_RESET = 2'd0,
        SEQ_HALT  = 2'd1,
        SEQ_RUN   = 2'd2
    } seq_state_e;

    // Straps kept from the reset release edge
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              smb_slow;
        logic              cclk_dn;
        logic              cclk_up;
        logic              halt;
    } strap_t;

    typedef struct packed {
        logic eeprom_en;
        logic failover_en;
        logic up_sel;      // 0: port 0 upstream, 1: port 2 upstream
        logic bad;
    } mode_dec_t;

    function automatic mode_dec_t decode_mode(input logic [MODE_W-1:0] m);
        mode_dec_t d;
        d = '0;
        case (m)
            4'h0: d = '0;
            4'h1: d.eeprom_en = 1'b1;
            4'h8: d.failover_en = 1'b1;
            4'h9: begin
                d.failover_en = 1'b1;
                d.up_sel      = 1'b1;
            end
            4'hA: begin
                d.eeprom_en   = 1'b1;
                d.failover_en = 1'b1;
            end
            4'hB: begin
                d.eeprom_en   = 1'b1;
                d.failover_en = 1'b1;
                d.up_sel      = 1'b1;
            end
            default: d.bad = 1'b1;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rstcfg_sync.sv
module rstcfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_in,
    output logic rst_out
);
    logic [STAGES-1:0] chain;

    // Assertion is seen at once, release walks through the chain
    always_ff @(posedge clk) begin
        if (rst_in) chain <= '1;
        else        chain <= {chain[STAGES-2:0], 1'b0};
    end

    assign rst_out = chain[STAGES-1];
endmodule

// File: rtl/rstcfg_seq.sv
module rstcfg_seq
    import rstcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       halt_req,
    input  logic       release_wr,
    output seq_state_e state,
    output logic       done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_RESET;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SEQ_RESET: begin
                    if (halt_req) begin
                        state <= SEQ_HALT;
                    end else begin
                        state <= SEQ_RUN;
                        done  <= 1'b1;
                    end
                end
                SEQ_HALT: begin
                    if (release_wr) begin
                        state <= SEQ_RUN;
                        done  <= 1'b1;
                    end
                end
                SEQ_RUN: state <= SEQ_RUN;
                default: state <= SEQ_RESET;
            endcase
        end
    end
endmodule

// File: rtl/rstcfg_pairmap.sv
module rstcfg_pairmap
    import rstcfg_pkg::*;
#(
    parameter int PAIR_IDX = 0,
    parameter int PORT_W   = 3
) (
    input  logic                                merged,
    output logic [LANES_PER_PAIR*PORT_W-1:0]     lane_port,
    output logic [LANES_PER_PAIR*LANE_IDX_W-1:0] lane_sub
);
    localparam logic [PORT_W-1:0] EVEN_PORT = PORT_W'(2 * PAIR_IDX);
    localparam logic [PORT_W-1:0] ODD_PORT  = PORT_W'(2 * PAIR_IDX + 1);

    for (genvar k = 0; k < LANES_PER_PAIR; k++) begin : g_lane
        if (k < HALF_LANES) begin : g_low
            assign lane_port[k*PORT_W +: PORT_W]         = EVEN_PORT;
            assign lane_sub[k*LANE_IDX_W +: LANE_IDX_W]  = LANE_IDX_W'(k);
        end else begin : g_high
            assign lane_port[k*PORT_W +: PORT_W] = merged ? EVEN_PORT : ODD_PORT;
            assign lane_sub[k*LANE_IDX_W +: LANE_IDX_W] =
                merged ? LANE_IDX_W'(k) : LANE_IDX_W'(k - HALF_LANES);
        end
    end
endmodule

// File: rtl/rstcfg_ctrl.sv
module rstcfg_ctrl
    import rstcfg_pkg::*;
#(
    parameter int unsigned            NPAIR       = 3,
    parameter int unsigned            ADDR_W      = 4,
    parameter logic [ADDR_W-1:0]      CTL_ADDR    = '0,
    parameter int unsigned            SYNC_STAGES = 2,
    localparam int unsigned           NPORT       = 2 * NPAIR,
    localparam int unsigned           PORT_W      = $clog2(NPORT),
    localparam int unsigned           NLANE       = NPAIR * LANES_PER_PAIR
) (
    input  logic                        clk,
    input  logic                        rst_fund,
    input  logic [MODE_W-1:0]           strap_mode,
    input  logic [NPAIR-1:0]            strap_merge_n,
    input  logic                        strap_smb_slow,
    input  logic                        strap_cclk_dn,
    input  logic                        strap_cclk_up,
    input  logic                        strap_halt,
    input  logic                        ctl_we,
    input  logic [ADDR_W-1:0]           ctl_addr,
    input  logic                        ctl_wdata,
    output logic                        core_rst,
    output logic                        halted,
    output logic                        mgmt_active,
    output logic                        cfg_done,
    output logic                        cfg_error,
    output logic                        eeprom_init_en,
    output logic                        failover_en,
    output logic [PORT_W-1:0]           upstream_port,
    output logic                        smb_slow,
    output logic                        cclk_dn,
    output logic                        cclk_up,
    output logic [NPAIR-1:0]            pair_merged,
    output logic [NLANE*PORT_W-1:0]     lane_port,
    output logic [NLANE*LANE_IDX_W-1:0] lane_sub
);
    localparam int unsigned PAIR_PW = LANES_PER_PAIR * PORT_W;
    localparam int unsigned PAIR_SW = LANES_PER_PAIR * LANE_IDX_W;

    logic       rst_int;
    strap_t     held;
    logic [NPAIR-1:0] held_merge_n;
    mode_dec_t  dec;
    seq_state_e state;
    logic       release_wr;

    rstcfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_in  (rst_fund),
        .rst_out (rst_int)
    );

    // Follow the pins during reset; last sample is the release-edge value
    always_ff @(posedge clk) begin
        if (rst_int) begin
            held         <= {strap_mode, strap_smb_slow, strap_cclk_dn,
                             strap_cclk_up, strap_halt};
            held_merge_n <= strap_merge_n;
        end
    end

    assign release_wr = ctl_we && (ctl_addr == CTL_ADDR) && !ctl_wdata;

    rstcfg_seq u_seq (
        .clk        (clk),
        .rst        (rst_int),
        .halt_req   (held.halt),
        .release_wr (release_wr),
        .state      (state),
        .done       (cfg_done)
    );

    assign core_rst    = (state != SEQ_RUN);
    assign halted      = (state == SEQ_HALT);
    assign mgmt_active = (state != SEQ_RESET);

    always_comb begin
        dec            = decode_mode(held.mode);
        cfg_error      = dec.bad;
        eeprom_init_en = dec.eeprom_en;
        failover_en    = dec.failover_en;
        upstream_port  = (dec.failover_en && dec.up_sel) ? PORT_W'(2) : '0;
    end

    assign smb_slow    = held.smb_slow;
    assign cclk_dn     = held.cclk_dn;
    assign cclk_up     = held.cclk_up;
    assign pair_merged = ~held_merge_n;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        rstcfg_pairmap #(.PAIR_IDX(p), .PORT_W(PORT_W)) u_map (
            .merged    (pair_merged[p]),
            .lane_port (lane_port[p*PAIR_PW +: PAIR_PW]),
            .lane_sub  (lane_sub[p*PAIR_SW +: PAIR_SW])
        );
    end
endmodule

// File: rtl/rstcfg_chk.sv
module rstcfg_chk #(
    parameter int unsigned       NPAIR    = 3,
    parameter int unsigned       ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] CTL_ADDR = '0
) (
    input logic              clk,
    input logic              rst_fund,
    input logic              ctl_we,
    input logic [ADDR_W-1:0] ctl_addr,
    input logic              ctl_wdata,
    input logic              core_rst,
    input logic              halted,
    input logic              mgmt_active,
    input logic              cfg_done,
    input logic              cfg_error,
    input logic              eeprom_init_en,
    input logic              failover_en,
    input logic              smb_slow,
    input logic              cclk_dn,
    input logic              cclk_up,
    input logic [NPAIR-1:0]  pair_merged
);
    logic clr_wr;
    assign clr_wr = ctl_we && (ctl_addr == CTL_ADDR) && !ctl_wdata;

    // R1: a reset held for two samples keeps the core and management side down
    assert_fund_hold_R1: assert property (@(posedge clk)
        rst_fund && $past(rst_fund) |=> core_rst && !mgmt_active && !cfg_done);

    // R2: held straps do not move while running
    assert_straps_stable_R2: assert property (@(posedge clk) disable iff (rst_fund)
        !core_rst |-> $stable(eeprom_init_en) && $stable(failover_en) &&
                      $stable(smb_slow) && $stable(cclk_dn) && $stable(cclk_up) &&
                      $stable(pair_merged) && $stable(cfg_error));

    // R4: reserved codes fall back to plain operation
    assert_err_fallback_R4: assert property (@(posedge clk) disable iff (rst_fund)
        cfg_error |-> !eeprom_init_en && !failover_en);

    // R9: without the clearing write the halt persists
    assert_halt_holds_R9: assert property (@(posedge clk) disable iff (rst_fund)
        halted && !$past(rst_fund) && !$past(rst_fund, 2) && !clr_wr |=> halted);

    // R9: the clearing write releases into normal operation
    assert_halt_release_R9: assert property (@(posedge clk) disable iff (rst_fund)
        halted && !$past(rst_fund) && !$past(rst_fund, 2) && clr_wr |=> !core_rst && cfg_done);

    // R10: done is a single-cycle pulse coinciding with normal operation
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst_fund)
        cfg_done |=> !cfg_done);
    assert_done_running_R10: assert property (@(posedge clk) disable iff (rst_fund)
        cfg_done |-> !core_rst && !halted);

    // R11: once running, nothing but reset stops the core
    assert_run_sticky_R11: assert property (@(posedge clk) disable iff (rst_fund)
        !core_rst && !$past(rst_fund) && !$past(rst_fund, 2) |=> !core_rst && !halted);
endmodule

bind rstcfg_ctrl rstcfg_chk #(
    .NPAIR    (NPAIR),
    .ADDR_W   (ADDR_W),
    .CTL_ADDR (CTL_ADDR)
) u_chk (
    .clk            (clk),
    .rst_fund       (rst_fund),
    .ctl_we         (ctl_we),
    .ctl_addr       (ctl_addr),
    .ctl_wdata      (ctl_wdata),
    .core_rst       (core_rst),
    .halted         (halted),
    .mgmt_active    (mgmt_active),
    .cfg_done       (cfg_done),
    .cfg_error      (cfg_error),
    .eeprom_init_en (eeprom_init_en),
    .failover_en    (failover_en),
    .smb_slow       (smb_slow),
    .cclk_dn        (cclk_dn),
    .cclk_up        (cclk_up),
    .pair_merged    (pair_merged)
);

// File: tb/rstcfg_ctrl_test.sv
module rstcfg_ctrl_test;
    localparam int NPAIR  = 3;
    localparam int ADDR_W = 4;
    localparam int PORT_W = 3;
    localparam int NLANE  = NPAIR * 8;

    logic clk = 1'b0;
    logic rst_fund = 1'b1;
    logic [3:0] strap_mode = '0;
    logic [NPAIR-1:0] strap_merge_n = '1;
    logic strap_smb_slow = 1'b0, strap_cclk_dn = 1'b0, strap_cclk_up = 1'b0, strap_halt = 1'b0;
    logic ctl_we = 1'b0;
    logic [ADDR_W-1:0] ctl_addr = '0;
    logic ctl_wdata = 1'b0;

    logic core_rst, halted, mgmt_active, cfg_done, cfg_error, eeprom_init_en, failover_en;
    logic [PORT_W-1:0] upstream_port;
    logic smb_slow, cclk_dn, cclk_up;
    logic [NPAIR-1:0] pair_merged;
    logic [NLANE*PORT_W-1:0] lane_port;
    logic [NLANE*3-1:0] lane_sub;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rstcfg_ctrl uut (
        .clk(clk), .rst_fund(rst_fund), .strap_mode(strap_mode),
        .strap_merge_n(strap_merge_n), .strap_smb_slow(strap_smb_slow),
        .strap_cclk_dn(strap_cclk_dn), .strap_cclk_up(strap_cclk_up),
        .strap_halt(strap_halt), .ctl_we(ctl_we), .ctl_addr(ctl_addr),
        .ctl_wdata(ctl_wdata), .core_rst(core_rst), .halted(halted),
        .mgmt_active(mgmt_active), .cfg_done(cfg_done), .cfg_error(cfg_error),
        .eeprom_init_en(eeprom_init_en), .failover_en(failover_en),
        .upstream_port(upstream_port), .smb_slow(smb_slow), .cclk_dn(cclk_dn),
        .cclk_up(cclk_up), .pair_merged(pair_merged), .lane_port(lane_port),
        .lane_sub(lane_sub)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Apply straps, pulse reset, release and check the release timing
    task automatic do_reset(input logic [3:0] mode, input logic [NPAIR-1:0] mn,
                            input logic halt, input logic slow,
                            input logic dn, input logic up);
        @(negedge clk);
        rst_fund = 1'b1;
        strap_mode = mode; strap_merge_n = mn; strap_halt = halt;
        strap_smb_slow = slow; strap_cclk_dn = dn; strap_cclk_up = up;
        repeat (4) @(negedge clk);
        chk("R1", "core_rst in reset", 32'(core_rst), 1);
        chk("R1", "mgmt_active in reset", 32'(mgmt_active), 0);
        chk("R1", "cfg_done in reset", 32'(cfg_done), 0);
        rst_fund = 1'b0;
        @(negedge clk);
        chk("R1", "core_rst after E0", 32'(core_rst), 1);
        @(negedge clk);
        chk("R1", "core_rst after E1", 32'(core_rst), 1);
        @(negedge clk);
        if (!halt) begin
            chk("R1", "core_rst after E2", 32'(core_rst), 0);
            chk("R10", "done on direct entry", 32'(cfg_done), 1);
            @(negedge clk);
            chk("R10", "done one cycle", 32'(cfg_done), 0);
        end else begin
            chk("R8", "halted", 32'(halted), 1);
            chk("R8", "mgmt_active halted", 32'(mgmt_active), 1);
            chk("R8", "core_rst halted", 32'(core_rst), 1);
            chk("R8", "no done while halted", 32'(cfg_done), 0);
        end
    endtask

    task automatic ctl_write(input logic [ADDR_W-1:0] a, input logic d);
        ctl_we = 1'b1; ctl_addr = a; ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0; ctl_addr = '0; ctl_wdata = 1'b0;
    endtask

    task automatic chk_lanes(input logic [NPAIR-1:0] mn);
        for (int p = 0; p < NPAIR; p++) begin
            chk(mn[p] ? "R6" : "R5", "pair_merged", 32'(pair_merged[p]), 32'(!mn[p]));
            for (int k = 0; k < 8; k++) begin
                int n;
                int ep, es;
                n  = p * 8 + k;
                ep = (k < 4 || !mn[p]) ? 2 * p : 2 * p + 1;
                es = !mn[p] ? k : k % 4;
                chk(mn[p] ? "R6" : "R5", $sformatf("lane %0d port", n),
                    32'(lane_port[n*PORT_W +: PORT_W]), 32'(ep));
                chk(mn[p] ? "R6" : "R5", $sformatf("lane %0d sub", n),
                    32'(lane_sub[n*3 +: 3]), 32'(es));
            end
        end
    endtask

    task automatic chk_mode(input string req, input logic ee, input logic fo,
                            input logic [PORT_W-1:0] up, input logic err);
        chk(req, "eeprom_init_en", 32'(eeprom_init_en), 32'(ee));
        chk(req, "failover_en", 32'(failover_en), 32'(fo));
        chk(req, "upstream_port", 32'(upstream_port), 32'(up));
        chk(req, "cfg_error", 32'(cfg_error), 32'(err));
    endtask

    task automatic t_normal();
        do_reset(4'h0, 3'b111, 1'b0, 1'b0, 1'b0, 1'b0);
        chk_mode("R3", 0, 0, 0, 0);
        chk_lanes(3'b111);
    endtask

    task automatic t_eeprom_merge();
        do_reset(4'h1, 3'b010, 1'b0, 1'b1, 1'b1, 1'b0);
        chk_mode("R3", 1, 0, 0, 0);
        chk_lanes(3'b010);
        chk("R7", "smb_slow", 32'(smb_slow), 1);
        chk("R2", "cclk_dn", 32'(cclk_dn), 1);
        chk("R2", "cclk_up", 32'(cclk_up), 0);
    endtask

    task automatic t_failover();
        do_reset(4'h8, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1);
        chk_mode("R3", 0, 1, 0, 0);
        chk_lanes(3'b000);
        chk("R2", "cclk_up", 32'(cclk_up), 1);
        do_reset(4'h9, 3'b101, 1'b0, 1'b0, 1'b0, 1'b0);
        chk_mode("R3", 0, 1, 2, 0);
        do_reset(4'hA, 3'b111, 1'b0, 1'b0, 1'b0, 1'b0);
        chk_mode("R3", 1, 1, 0, 0);
        do_reset(4'hB, 3'b111, 1'b0, 1'b0, 1'b0, 1'b0);
        chk_mode("R3", 1, 1, 2, 0);
    endtask

    task automatic t_reserved();
        logic [3:0] codes [4] = '{4'h2, 4'h7, 4'hC, 4'hF};
        for (int i = 0; i < 4; i++) begin
            do_reset(codes[i], 3'b111, 1'b0, 1'b0, 1'b0, 1'b0);
            chk_mode("R4", 0, 0, 0, 1);
        end
    endtask

    task automatic t_static();
        do_reset(4'h9, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
        strap_mode = 4'h3; strap_merge_n = 3'b111; strap_smb_slow = 1'b1;
        strap_cclk_dn = 1'b1; strap_cclk_up = 1'b1; strap_halt = 1'b1;
        repeat (6) @(negedge clk);
        chk_mode("R2", 0, 1, 2, 0);
        chk("R2", "merge held", 32'(pair_merged), 32'h7);
        chk("R2", "smb_slow held", 32'(smb_slow), 0);
        chk("R2", "cclk_dn held", 32'(cclk_dn), 0);
        chk("R2", "cclk_up held", 32'(cclk_up), 0);
        chk("R2", "still running", 32'(core_rst), 0);
    endtask

    task automatic t_halt();
        do_reset(4'hA, 3'b110, 1'b1, 1'b1, 1'b0, 1'b0);
        chk_mode("R3", 1, 1, 0, 0);
        ctl_write(4'h1, 1'b0);
        chk("R9", "wrong addr keeps halt", 32'(halted), 1);
        chk("R9", "no done wrong addr", 32'(cfg_done), 0);
        ctl_write(4'h0, 1'b1);
        chk("R9", "data 1 keeps halt", 32'(halted), 1);
        chk("R9", "core_rst still", 32'(core_rst), 1);
        repeat (3) @(negedge clk);
        chk("R9", "halt persists idle", 32'(halted), 1);
        ctl_write(4'h0, 1'b0);
        chk("R9", "released", 32'(core_rst), 0);
        chk("R9", "halted cleared", 32'(halted), 0);
        chk("R10", "done on release", 32'(cfg_done), 1);
        @(negedge clk);
        chk("R10", "done one cycle after release", 32'(cfg_done), 0);
        chk("R7", "smb_slow after release", 32'(smb_slow), 1);
    endtask

    task automatic t_running_write();
        do_reset(4'h0, 3'b111, 1'b0, 1'b1, 1'b0, 1'b0);
        ctl_write(4'h0, 1'b1);
        chk("R11", "write 1 no halt", 32'(halted), 0);
        chk("R11", "write 1 core runs", 32'(core_rst), 0);
        chk("R7", "smb_slow unchanged", 32'(smb_slow), 1);
        ctl_write(4'h0, 1'b0);
        chk("R11", "write 0 core runs", 32'(core_rst), 0);
        chk("R10", "no done while running", 32'(cfg_done), 0);
        ctl_write(4'hF, 1'b1);
        chk("R11", "other addr core runs", 32'(core_rst), 0);
        chk("R7", "smb_slow still", 32'(smb_slow), 1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_normal();
        t_eeprom_merge();
        t_failover();
        t_reserved();
        t_static();
        t_halt();
        t_running_write();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule